// File: doc/BRIEF.md
# Multi-Slot Asynchronous Photon Up/Down Counter

This block is one channel of a photon counter used to demodulate a laser-modulated fluorescence signal. A discriminator sends short pulses, about 5 ns wide, at rates up to a 200 MHz pulse clock. The pulses have no timing relation to the 50 MHz system clock. Each pulse is caught by one of several parallel capture slots. In each slot, a flip-flop clocked by the pulse and a flip-flop clocked by the system clock form a mismatch flag. The slot then completes a short synchronising handshake, and when the handshake ends the pulse is credited to a signed accumulator.

A fixed-priority addresser looks at the busy line of every slot and steers each new pulse to the lowest-numbered idle slot. A burst of pulses that arrives faster than one slot can recover is therefore still counted. The external up/down state input sets the sign of each credit, so counting up while the laser is on and down while it is off removes the steady background. A sample strobe, issued once per modulation period, copies the accumulated count to the output and starts a new period from zero.

Top module: `phc_updown_counter`

## Requirements
- R1: After reset, sample_data is 0, sample_valid is 0 and overflow is 0.
- R2: Each captured pulse changes the accumulator by +1 when count_up is 1 and by -1 when count_up is 0. The sign is the value of count_up on the clock edge where the pulse is credited.
- R3: Up to NUM_SLOTS pulses arriving 10 ns apart, which is closer than one slot's busy time, are all counted. Each pulse goes to the lowest-index idle slot.
- R4: A pulse that arrives while every slot is busy is not counted and sets overflow. Overflow then stays 1 until reset.
- R5: When several slots complete on the same clock edge, all of their credits are added to the accumulator on that edge.
- R6: The accumulator saturates at +(2^(ACC_W-1))-1 and at -(2^(ACC_W-1)) and never wraps. After sitting at a limit, it moves away from that limit normally.
- R7: On a clock edge where sample_stb is 1, sample_data takes the accumulated count from before that edge and the accumulator restarts from zero. sample_valid is 1 in the cycle after a strobe edge and 0 in all other cycles. sample_data is unchanged on edges without a strobe.
- R8: A pulse whose rising edge falls between clock edges E0 and E1 is credited on edge E4. If the strobe is on E4, that sample excludes the pulse and the new period includes it.
- R9: Each pulse is captured by at most one slot, so a burst of n pulses (n no greater than NUM_SLOTS) adds exactly n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset for both the pulse and clock domains |
| pulse_in | input | 1 | Asynchronous discriminator pulse; its rising edge is one photon |
| count_up | input | 1 | Credit sign: 1 counts up, 0 counts down |
| sample_stb | input | 1 | End-of-period strobe: samples the count and clears the accumulator |
| sample_data | output | ACC_W | Signed count of the last completed period |
| sample_valid | output | 1 | 1 in the cycle after a strobe edge |
| overflow | output | 1 | Sticky flag: a pulse was dropped because all slots were busy |

## Verification
Single pulses and short bursts are sent with each sign. They separate the up and down credit paths and show whether a burst spaced closer than one slot's recovery time is spread over the slots or partly lost. A burst of four pulses packed into one clock period makes all slots finish on the same edge, which exposes an accumulator that credits only one completion per cycle. A fifth pulse in a 10 ns burst shows the dropped-pulse path. A strobe placed exactly on the credit edge shows which period the credit lands in. Long runs of same-sign bursts drive the count into both limits and then back off each limit. Randomly mixed bursts, spacings, signs and strobe points are checked against a bench model of the running count.

// File: rtl/phc_pkg.sv
`timescale 1ns/1ps
package phc_pkg;

   // Slot life cycle seen from the system clock domain.
   typedef enum logic [0:0] {
      SLOT_WAIT  = 1'b0,   // watching the synchronised mismatch flag
      SLOT_DRAIN = 1'b1    // flag cleared, waiting for the synchroniser to empty
   } slot_state_e;

   // Width needed for a count of 0..n.
   function automatic int cnt_width(input int n);
      return $clog2(n + 1);
   endfunction

endpackage

// File: rtl/phc_capture_slot.sv
`timescale 1ns/1ps
module phc_capture_slot
   import phc_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse_in,
   input  logic grant,
   output logic busy,
   output logic done
);

   localparam int DRAIN_W = $clog2(SYNC_STAGES) + 1;

   logic                   set_q;     // pulse-domain half of the flag pair
   logic                   clr_q;     // clock-domain half of the flag pair
   logic                   flag;
   logic [SYNC_STAGES-1:0] sync_q;
   slot_state_e            state_q;
   logic [DRAIN_W-1:0]     drain_q;
   logic                   done_q;

   // A granted pulse edge makes the two halves differ.
   always_ff @(posedge pulse_in or negedge rst_n) begin
      if (!rst_n)     set_q <= 1'b0;
      else if (grant) set_q <= ~clr_q;
   end

   assign flag = set_q ^ clr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], flag};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clr_q   <= 1'b0;
         state_q <= SLOT_WAIT;
         drain_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            SLOT_WAIT: begin
               if (sync_q[SYNC_STAGES-1]) begin
                  done_q  <= 1'b1;
                  clr_q   <= set_q;
                  state_q <= SLOT_DRAIN;
                  drain_q <= DRAIN_W'(SYNC_STAGES - 1);
               end
            end
            SLOT_DRAIN: begin
               if (drain_q == '0) state_q <= SLOT_WAIT;
               else               drain_q <= drain_q - 1'b1;
            end
            default: state_q <= SLOT_WAIT;
         endcase
      end
   end

   assign busy = flag | (|sync_q) | (state_q != SLOT_WAIT);
   assign done = done_q;

endmodule

// File: rtl/phc_slot_arbiter.sv
`timescale 1ns/1ps
module phc_slot_arbiter #(
   parameter int NUM_SLOTS = 4
) (
   input  logic [NUM_SLOTS-1:0] busy,
   output logic [NUM_SLOTS-1:0] grant,
   output logic                 all_busy
);

   // Fixed priority: the lowest-index idle slot wins.
   always_comb begin
      logic found;
      found = 1'b0;
      grant = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (!busy[i] && !found) begin
            grant[i] = 1'b1;
            found    = 1'b1;
         end
      end
   end

   assign all_busy = &busy;

endmodule

// File: rtl/phc_accumulator.sv
`timescale 1ns/1ps
module phc_accumulator
   import phc_pkg::*;
#(
   parameter int NUM_SLOTS = 4,
   parameter int ACC_W     = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_SLOTS-1:0]    done_vec,
   input  logic                    count_up,
   input  logic                    sample_stb,
   output logic signed [ACC_W-1:0] acc,
   output logic signed [ACC_W-1:0] sample_data,
   output logic                    sample_valid
);

   localparam int CNT_W = cnt_width(NUM_SLOTS);
   localparam int EXT_W = ACC_W + 2;
   localparam logic signed [EXT_W-1:0] LIM_HI = {3'b000, {(ACC_W-1){1'b1}}};
   localparam logic signed [EXT_W-1:0] LIM_LO = {3'b111, {(ACC_W-1){1'b0}}};

   logic [CNT_W-1:0]        n_done;
   logic signed [EXT_W-1:0] step;
   logic signed [EXT_W-1:0] base;
   logic signed [EXT_W-1:0] sum;
   logic signed [EXT_W-1:0] clamped;

   always_comb begin
      n_done = '0;
      for (int i = 0; i < NUM_SLOTS; i++) n_done = n_done + CNT_W'(done_vec[i]);
   end

   always_comb begin
      logic signed [EXT_W-1:0] mag;
      mag  = $signed({{(EXT_W-CNT_W){1'b0}}, n_done});
      step = count_up ? mag : -mag;
      // A strobe restarts the period; this edge's credits go to the new one.
      base = sample_stb ? '0 : EXT_W'(acc);
      sum  = base + step;
      if (sum > LIM_HI)      clamped = LIM_HI;
      else if (sum < LIM_LO) clamped = LIM_LO;
      else                   clamped = sum;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc          <= '0;
         sample_data  <= '0;
         sample_valid <= 1'b0;
      end else begin
         acc          <= clamped[ACC_W-1:0];
         sample_valid <= sample_stb;
         if (sample_stb) sample_data <= acc;
      end
   end

endmodule

// File: rtl/phc_updown_counter.sv
`timescale 1ns/1ps
module phc_updown_counter #(
   parameter int NUM_SLOTS   = 4,
   parameter int ACC_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    pulse_in,
   input  logic                    count_up,
   input  logic                    sample_stb,
   output logic signed [ACC_W-1:0] sample_data,
   output logic                    sample_valid,
   output logic                    overflow
);

   if (NUM_SLOTS < 1 || NUM_SLOTS > 32) begin : g_chk_slots
      $error("NUM_SLOTS must be 1..32");
   end
   if (ACC_W < 4 || ACC_W > 30) begin : g_chk_width
      $error("ACC_W must be 4..30");
   end
   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_chk_sync
      $error("SYNC_STAGES must be 2..4");
   end
   if ((1 << (ACC_W - 2)) <= NUM_SLOTS) begin : g_chk_ratio
      $error("ACC_W too narrow for NUM_SLOTS");
   end

   logic [NUM_SLOTS-1:0]    slot_busy;
   logic [NUM_SLOTS-1:0]    slot_grant;
   logic [NUM_SLOTS-1:0]    slot_done;
   logic                    all_busy;
   logic signed [ACC_W-1:0] acc_q;
   logic                    ovf_p;
   logic [1:0]              ovf_sync_q;

   phc_slot_arbiter #(.NUM_SLOTS(NUM_SLOTS)) u_arb (
      .busy     (slot_busy),
      .grant    (slot_grant),
      .all_busy (all_busy)
   );

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      phc_capture_slot #(.SYNC_STAGES(SYNC_STAGES)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .pulse_in (pulse_in),
         .grant    (slot_grant[s]),
         .busy     (slot_busy[s]),
         .done     (slot_done[s])
      );
   end

   phc_accumulator #(.NUM_SLOTS(NUM_SLOTS), .ACC_W(ACC_W)) u_acc (
      .clk          (clk),
      .rst_n        (rst_n),
      .done_vec     (slot_done),
      .count_up     (count_up),
      .sample_stb   (sample_stb),
      .acc          (acc_q),
      .sample_data  (sample_data),
      .sample_valid (sample_valid)
   );

   // Dropped pulse: record it in the pulse domain, then bring it across.
   always_ff @(posedge pulse_in or negedge rst_n) begin
      if (!rst_n)        ovf_p <= 1'b0;
      else if (all_busy) ovf_p <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovf_sync_q <= '0;
      else        ovf_sync_q <= {ovf_sync_q[0], ovf_p};
   end

   assign overflow = ovf_sync_q[1];

endmodule

// File: rtl/phc_updown_counter_chk.sv
`timescale 1ns/1ps
module phc_updown_counter_chk #(
   parameter int NUM_SLOTS = 4,
   parameter int ACC_W     = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    count_up,
   input logic                    sample_stb,
   input logic signed [ACC_W-1:0] sample_data,
   input logic                    sample_valid,
   input logic                    overflow,
   input logic signed [ACC_W-1:0] acc_q,
   input logic [NUM_SLOTS-1:0]    slot_grant
);

   a_r7_valid_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |=> sample_valid);

   a_r7_no_valid_without_stb: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_stb |=> !sample_valid);

   a_r7_hold_sample: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_stb |=> $stable(sample_data));

   a_r4_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   // R2 sign and R6 no wrap at the upper limit
   a_r6_up_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!sample_stb && count_up) |=> (acc_q >= $past(acc_q)));

   // R2 sign and R6 no wrap at the lower limit
   a_r6_down_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!sample_stb && !count_up) |=> (acc_q <= $past(acc_q)));

   a_r9_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slot_grant));

endmodule

bind phc_updown_counter phc_updown_counter_chk #(
   .NUM_SLOTS (NUM_SLOTS),
   .ACC_W     (ACC_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .count_up     (count_up),
   .sample_stb   (sample_stb),
   .sample_data  (sample_data),
   .sample_valid (sample_valid),
   .overflow     (overflow),
   .acc_q        (acc_q),
   .slot_grant   (slot_grant)
);

// File: tb/phc_updown_counter_bench.sv
`timescale 1ns/1ps
module phc_updown_counter_bench;

   localparam int NS = 4;
   localparam int W  = 10;
   localparam int HI = 511;
   localparam int LO = -512;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pulse_in = 1'b0;
   logic count_up = 1'b0;
   logic sample_stb = 1'b0;
   logic signed [W-1:0] sample_data;
   logic sample_valid;
   logic overflow;

   int checks = 0;
   int errors = 0;
   int model = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   phc_updown_counter #(.NUM_SLOTS(NS), .ACC_W(W)) u_phc_updown_counter (
      .clk          (clk),
      .rst_n        (rst_n),
      .pulse_in     (pulse_in),
      .count_up     (count_up),
      .sample_stb   (sample_stb),
      .sample_data  (sample_data),
      .sample_valid (sample_valid),
      .overflow     (overflow)
   );

   function automatic int sat(input int v);
      if (v > HI) return HI;
      if (v < LO) return LO;
      return v;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // n pulses starting 2 ns after a clock edge, then enough idle cycles for every slot to free up.
   task automatic burst(input int n, input int spacing, input int width, input bit up);
      @(negedge clk) count_up = up;
      @(posedge clk);
      #2;
      for (int i = 0; i < n; i++) begin
         pulse_in = 1'b1;
         #(width);
         pulse_in = 1'b0;
         #(spacing - width);
      end
      repeat (10) @(negedge clk);
   endtask

   task automatic take_sample(input string req, input int exp);
      @(negedge clk) sample_stb = 1'b1;
      @(negedge clk) sample_stb = 1'b0;
      check({req, " valid"}, int'(sample_valid), 1);
      check(req, int'(sample_data), exp);
      model = 0;
   endtask

   initial begin
      void'($urandom(32'd9173));
      repeat (3) @(negedge clk);
      check("R1 sample_data", int'(sample_data), 0);
      check("R1 sample_valid", int'(sample_valid), 0);
      check("R1 overflow", int'(overflow), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R7 no valid without strobe", int'(sample_valid), 0);

      burst(1, 10, 5, 1'b1);
      take_sample("R2 single up", 1);
      burst(3, 10, 5, 1'b0);
      take_sample("R2 three down", -3);

      burst(4, 10, 5, 1'b1);
      take_sample("R3 four-pulse burst at 10 ns", 4);
      check("R4 no overflow at full use", int'(overflow), 0);

      burst(4, 4, 2, 1'b0);
      take_sample("R5 same-edge completions", -4);

      // R8: pulse between E0 and E1, strobe on E4.
      @(negedge clk) count_up = 1'b1;
      @(posedge clk);
      #2 pulse_in = 1'b1;
      #5 pulse_in = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk) sample_stb = 1'b1;
      @(negedge clk) sample_stb = 1'b0;
      check("R8 strobe on credit edge excludes pulse", int'(sample_data), 0);
      repeat (4) @(negedge clk);
      take_sample("R8 credit lands in new period", 1);

      burst(5, 10, 5, 1'b1);
      take_sample("R4 fifth pulse dropped", 4);
      check("R4 overflow set", int'(overflow), 1);

      for (int k = 0; k < 80; k++) begin
         int n;
         bit up;
         bit tight;
         n = int'($urandom % 5);
         up = 1'($urandom % 2);
         tight = 1'($urandom % 2);
         if (tight) burst(n, 4, 2, up);
         else       burst(n, 10, 5, up);
         model = sat(up ? model + n : model - n);
         if ($urandom % 3 == 0) take_sample("R9 random burst sum", model);
      end
      take_sample("R9 random final sum", model);

      for (int k = 0; k < 140; k++) burst(4, 10, 5, 1'b1);
      take_sample("R6 upper limit", HI);
      for (int k = 0; k < 140; k++) burst(4, 10, 5, 1'b1);
      burst(4, 10, 5, 1'b0);
      take_sample("R6 leave upper limit", HI - 4);
      for (int k = 0; k < 140; k++) burst(4, 10, 5, 1'b0);
      take_sample("R6 lower limit", LO);
      for (int k = 0; k < 140; k++) burst(4, 10, 5, 1'b0);
      burst(3, 10, 5, 1'b1);
      take_sample("R6 leave lower limit", LO + 3);

      check("R4 overflow still set", int'(overflow), 1);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule